// File: doc/BRIEF.md
# Dual-Bank USB Host Transfer Launcher

This block sits between a host controller's register bus and its packet engine. Software describes up to two host transfers, one in bank A and one in bank B. Each bank has a control byte and a buffer base-address byte, written over a byte-wide register port. When a bank is both enabled and armed, the block sends the packet engine a single-cycle launch pulse. The pulse comes with a held descriptor: the bank number, the transfer direction, the data toggle, the preamble and isochronous flags, and the buffer base address.

Only one transfer is in flight at a time. A bank may ask to wait for the next start-of-frame tick before it launches. When both banks are ready in the same cycle, bank A goes first. When the engine reports completion, the block drops the arm bit of the bank that was in flight and sets a sticky per-bank completion flag. Any flag that is set drives the interrupt line. The speed-mode input qualifies two features: in direct low-speed operation the SOF wait and the preamble request have no effect.

Top module: `usb_host_xfer_launcher`

## Requirements
- R1: Register addresses are 0x0 (control A), 0x1 (base A), 0x8 (control B), 0x9 (base B) and 0xF (completion flags: bit0 = A, bit1 = B). All of them read back through `reg_rdata`, and all read 0 after reset. Control bits: 7 preamble, 6 toggle, 5 SOF-wait, 4 isochronous, 3 reserved (always reads 0), 2 direction, 1 enable, 0 arm.
- R2: A bank whose enable bit is 0 never launches, even when its arm bit is 1.
- R3: When an idle block sees an enabled, armed bank, `launch_go` is high for exactly one cycle, one clock after the control write. In that cycle the outputs carry the bank, direction (1 = OUT), toggle, isochronous flag and base address. These outputs hold until the next launch.
- R4: For an IN transfer (direction 0), `launch_toggle` is 0 whatever the toggle bit holds.
- R5: With SOF-wait set and `low_speed` at 0, a bank launches only after an `sof_tick` that arrives after its last control write, one clock after that tick. With `low_speed` at 1, the SOF-wait bit has no effect.
- R6: `launch_preamble` follows the preamble bit, but reads 0 when `low_speed` is 1.
- R7: When both banks become ready in the same cycle, bank A launches. Bank B launches one clock after the completion of A.
- R8: While a transfer is in flight (`xfer_busy` = 1), `launch_go` stays low.
- R9: An `eng_done` pulse while busy clears the arm bit of the in-flight bank only, and sets that bank's flag. `irq` is the OR of the flags. An `eng_done` pulse while idle changes nothing.
- R10: Writing 1 to a flag bit at 0xF clears that flag. Writing 0 leaves it unchanged.
- R11: A control write that arms the in-flight bank does not cut the current transfer short. The arm bit reads 1 throughout. After the completion the arm bit stays 1, and the bank launches again one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| low_speed | input | 1 | 1 = direct low-speed mode |
| sof_tick | input | 1 | Pulse: the engine has sent a start-of-frame |
| eng_done | input | 1 | Pulse: the engine has finished the current transfer |
| launch_go | output | 1 | One-cycle launch request |
| launch_bank | output | 1 | Launched bank (0 = A, 1 = B) |
| launch_out | output | 1 | 1 = OUT transfer, 0 = IN |
| launch_toggle | output | 1 | Data toggle (DATA1 when 1) |
| launch_preamble | output | 1 | Send a preamble before the packet |
| launch_iso | output | 1 | Isochronous transfer |
| launch_base | output | 8 | Buffer base address |
| xfer_busy | output | 1 | A transfer is in flight |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach from the ports is two banks becoming ready in the very same cycle. A register write touches only one bank per cycle, so writes alone cannot arrange it. The bench sets SOF-wait on both banks, arms B and then A, and lets a single `sof_tick` release both together. It then checks that A goes first, that B stays armed while A is in flight, and that B launches in the cycle after A completes. Re-arming a bank during its own transfer is reached the same way: the arm write is issued between the launch pulse and `eng_done`.

// File: rtl/uhl_pkg.sv
package uhl_pkg;
    localparam int NUM_BANKS   = 2;
    localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 8;
    localparam int BANK_STRIDE = 8;
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(15);

    typedef struct packed {
        logic pre;
        logic tog;
        logic sync;
        logic iso;
        logic rsv;
        logic dir;
        logic en;
        logic arm;
    } ctrl_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              dir;
        logic              tog;
        logic              pre;
        logic              iso;
        logic [DATA_W-1:0] base;
    } desc_t;

    function automatic logic [ADDR_W-1:0] ctrl_addr(input int idx);
        return ADDR_W'(idx * BANK_STRIDE);
    endfunction

    function automatic logic [ADDR_W-1:0] base_addr(input int idx);
        return ADDR_W'(idx * BANK_STRIDE + 1);
    endfunction

    // Builds the launch descriptor, qualifying toggle by direction
    // and preamble by the speed mode.
    function automatic desc_t make_desc(input logic [BANK_W-1:0] id,
                                        input ctrl_t c,
                                        input logic [DATA_W-1:0] b,
                                        input logic ls);
        desc_t d;
        d.bank = id;
        d.dir  = c.dir;
        d.tog  = c.dir & c.tog;
        d.pre  = c.pre & ~ls;
        d.iso  = c.iso;
        d.base = b;
        return d;
    endfunction
endpackage

// File: rtl/uhl_bank_regs.sv
module uhl_bank_regs
    import uhl_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              low_speed,
    input  logic              sof_tick,
    input  logic              launch,
    input  logic              done,
    input  logic              in_flight,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] base_q,
    output logic              ready
);
    localparam logic [ADDR_W-1:0] CA = ctrl_addr(IDX);
    localparam logic [ADDR_W-1:0] BA = base_addr(IDX);

    logic  wr_ctrl, wr_base;
    ctrl_t wr_c, ctrl_d;
    logic  pend_q, pend_d;
    logic  sof_seen_q, sof_seen_d;
    logic  need_sof;

    assign wr_ctrl  = wr_en && (wr_addr == CA);
    assign wr_base  = wr_en && (wr_addr == BA);
    assign wr_c     = ctrl_t'(wr_data);
    assign need_sof = ctrl_q.sync && !low_speed;

    always_comb begin
        ctrl_d = ctrl_q;
        pend_d = pend_q;
        if (done) begin
            ctrl_d.arm = pend_q;
            pend_d     = 1'b0;
        end
        if (wr_ctrl) begin
            ctrl_d     = wr_c;
            ctrl_d.rsv = 1'b0;
            if (in_flight && !done) begin
                ctrl_d.arm = ctrl_q.arm;
                pend_d     = wr_c.arm;
            end
        end
    end

    always_comb begin
        sof_seen_d = sof_seen_q;
        if (launch || wr_ctrl)
            sof_seen_d = 1'b0;
        else if (sof_tick)
            sof_seen_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            base_q     <= '0;
            pend_q     <= 1'b0;
            sof_seen_q <= 1'b0;
        end else begin
            ctrl_q     <= ctrl_d;
            pend_q     <= pend_d;
            sof_seen_q <= sof_seen_d;
            if (wr_base)
                base_q <= wr_data;
        end
    end

    assign ready = ctrl_q.en && ctrl_q.arm && !in_flight &&
                   (!need_sof || sof_seen_q);

    // R9
    done_clears_arm_chk: assert property (@(posedge clk) disable iff (rst)
        done && !pend_q && !wr_ctrl |=> !ctrl_q.arm);
    // R2
    launch_needs_armed_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> ctrl_q.en && ctrl_q.arm);
    // R5
    sof_gate_chk: assert property (@(posedge clk) disable iff (rst)
        launch && ctrl_q.sync && !low_speed |-> sof_seen_q);
    // R11
    arm_held_chk: assert property (@(posedge clk) disable iff (rst)
        in_flight && !done |-> ctrl_q.arm);
endmodule

// File: rtl/uhl_launcher.sv
module uhl_launcher
    import uhl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_BANKS-1:0]              ready,
    input  ctrl_t [NUM_BANKS-1:0]             ctrl,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  base,
    input  logic                              low_speed,
    input  logic                              eng_done,
    output logic                              go,
    output desc_t                             desc,
    output logic                              busy,
    output logic [NUM_BANKS-1:0]              launch_vec,
    output logic [NUM_BANKS-1:0]              done_vec,
    output logic [NUM_BANKS-1:0]              in_flight_vec
);
    logic [BANK_W-1:0] sel, owner_q;
    logic              found, start;

    // Lowest index wins: scan downward so the last hit is the lowest.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (ready[i]) begin
                sel   = BANK_W'(i);
                found = 1'b1;
            end
        end
    end

    assign start = !busy && found;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_vec
        assign launch_vec[g]    = start && (sel == BANK_W'(g));
        assign in_flight_vec[g] = busy && (owner_q == BANK_W'(g));
        assign done_vec[g]      = eng_done && in_flight_vec[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            go      <= 1'b0;
            busy    <= 1'b0;
            owner_q <= '0;
            desc    <= '0;
        end else begin
            go <= start;
            if (start) begin
                busy    <= 1'b1;
                owner_q <= sel;
                desc    <= make_desc(sel, ctrl[sel], base[sel], low_speed);
            end else if (eng_done && busy) begin
                busy <= 1'b0;
            end
        end
    end

    // R8
    single_flight_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> $past(!busy));
    // R4
    in_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        go && !desc.dir |-> !desc.tog);
    // R6
    pre_low_speed_chk: assert property (@(posedge clk) disable iff (rst)
        go && $past(low_speed) |-> !desc.pre);
    // R7
    bank_a_first_chk: assert property (@(posedge clk) disable iff (rst)
        go && $past(ready[0]) |-> desc.bank == '0);
endmodule

// File: rtl/uhl_irq.sv
module uhl_irq
    import uhl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NUM_BANKS-1:0] wr_bits,
    input  logic [NUM_BANKS-1:0] done_vec,
    output logic [NUM_BANKS-1:0] flags,
    output logic                 irq
);
    logic                 wr_flag;
    logic [NUM_BANKS-1:0] clr;

    assign wr_flag = wr_en && (wr_addr == FLAG_ADDR);
    assign clr     = wr_flag ? wr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= (flags & ~clr) | done_vec;
    end

    assign irq = |flags;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
        // R9
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            done_vec[g] |=> flags[g]);
        // R10
        flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
            wr_flag && wr_bits[g] && !done_vec[g] |=> !flags[g]);
    end
endmodule

// File: rtl/usb_host_xfer_launcher.sv
module usb_host_xfer_launcher
    import uhl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              low_speed,
    input  logic              sof_tick,
    input  logic              eng_done,
    output logic              launch_go,
    output logic [BANK_W-1:0] launch_bank,
    output logic              launch_out,
    output logic              launch_toggle,
    output logic              launch_preamble,
    output logic              launch_iso,
    output logic [DATA_W-1:0] launch_base,
    output logic              xfer_busy,
    output logic              irq
);
    ctrl_t [NUM_BANKS-1:0]             ctrl_all;
    logic  [NUM_BANKS-1:0][DATA_W-1:0] base_all;
    logic  [NUM_BANKS-1:0]             ready_vec, launch_vec, done_vec, in_flight_vec;
    logic  [NUM_BANKS-1:0]             flags;
    desc_t                             desc;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        uhl_bank_regs #(.IDX(g)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (reg_wr),
            .wr_addr   (reg_addr),
            .wr_data   (reg_wdata),
            .low_speed (low_speed),
            .sof_tick  (sof_tick),
            .launch    (launch_vec[g]),
            .done      (done_vec[g]),
            .in_flight (in_flight_vec[g]),
            .ctrl_q    (ctrl_all[g]),
            .base_q    (base_all[g]),
            .ready     (ready_vec[g])
        );
    end

    uhl_launcher u_launch (
        .clk           (clk),
        .rst           (rst),
        .ready         (ready_vec),
        .ctrl          (ctrl_all),
        .base          (base_all),
        .low_speed     (low_speed),
        .eng_done      (eng_done),
        .go            (launch_go),
        .desc          (desc),
        .busy          (xfer_busy),
        .launch_vec    (launch_vec),
        .done_vec      (done_vec),
        .in_flight_vec (in_flight_vec)
    );

    uhl_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wr_bits  (reg_wdata[NUM_BANKS-1:0]),
        .done_vec (done_vec),
        .flags    (flags),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (reg_addr == ctrl_addr(i)) reg_rdata = ctrl_all[i];
            if (reg_addr == base_addr(i)) reg_rdata = base_all[i];
        end
        if (reg_addr == FLAG_ADDR) reg_rdata = DATA_W'(flags);
    end

    assign launch_bank     = desc.bank;
    assign launch_out      = desc.dir;
    assign launch_toggle   = desc.tog;
    assign launch_preamble = desc.pre;
    assign launch_iso      = desc.iso;
    assign launch_base     = desc.base;
endmodule

// File: tb/sim_usb_host_xfer_launcher.sv
module sim_usb_host_xfer_launcher;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       low_speed = 1'b0, sof_tick = 1'b0, eng_done = 1'b0;
    logic       launch_go, launch_bank, launch_out, launch_toggle;
    logic       launch_preamble, launch_iso, xfer_busy, irq;
    logic [7:0] launch_base;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    usb_host_xfer_launcher u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .low_speed(low_speed),
        .sof_tick(sof_tick), .eng_done(eng_done), .launch_go(launch_go),
        .launch_bank(launch_bank), .launch_out(launch_out),
        .launch_toggle(launch_toggle), .launch_preamble(launch_preamble),
        .launch_iso(launch_iso), .launch_base(launch_base),
        .xfer_busy(xfer_busy), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic pulse_sof();
        @(negedge clk); sof_tick = 1'b1;
        @(negedge clk); sof_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(4'h0, d); check("R1 ctrl A reset", d, 0);
        rd(4'h1, d); check("R1 base A reset", d, 0);
        rd(4'h8, d); check("R1 ctrl B reset", d, 0);
        rd(4'h9, d); check("R1 base B reset", d, 0);
        rd(4'hF, d); check("R1 flags reset", d, 0);
        check("R1 go reset", launch_go, 0);
        check("R1 busy reset", xfer_busy, 0);
        check("R1 irq reset", irq, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(4'h1, 8'h40); rd(4'h1, d); check("R1 base A readback", d, 8'h40);
        wr(4'h9, 8'h80); rd(4'h9, d); check("R1 base B readback", d, 8'h80);
        wr(4'h8, 8'h18); rd(4'h8, d); check("R1 ctrl B reserved bit", d, 8'h10);
        wr(4'h8, 8'h00);
    endtask

    task automatic t_enable_gate();
        logic [7:0] d;
        wr(4'h0, 8'h01);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2 no launch without enable", launch_go, 0);
        end
        check("R2 idle without enable", xfer_busy, 0);
        rd(4'h0, d); check("R2 arm kept", d, 8'h01);
        wr(4'h0, 8'h00);
    endtask

    task automatic t_out_launch();
        logic [7:0] d;
        wr(4'h0, 8'h57);
        @(negedge clk);
        check("R3 go", launch_go, 1);
        check("R3 bank", launch_bank, 0);
        check("R3 out", launch_out, 1);
        check("R3 toggle", launch_toggle, 1);
        check("R3 iso", launch_iso, 1);
        check("R3 base", launch_base, 8'h40);
        check("R6 pre off", launch_preamble, 0);
        @(negedge clk);
        check("R3 go single cycle", launch_go, 0);
        check("R3 busy", xfer_busy, 1);
        check("R3 base held", launch_base, 8'h40);
        pulse_done();
        rd(4'h0, d); check("R9 arm cleared", d, 8'h56);
        rd(4'hF, d); check("R9 flag A", d, 8'h01);
        check("R9 irq", irq, 1);
        check("R9 idle", xfer_busy, 0);
        wr(4'hF, 8'h00);
        rd(4'hF, d); check("R10 write 0 keeps", d, 8'h01);
        wr(4'hF, 8'h01);
        rd(4'hF, d); check("R10 w1c", d, 8'h00);
        check("R10 irq low", irq, 0);
    endtask

    task automatic t_in_toggle();
        wr(4'h0, 8'h43);
        @(negedge clk);
        check("R4 go", launch_go, 1);
        check("R4 in dir", launch_out, 0);
        check("R4 toggle masked", launch_toggle, 0);
        pulse_done();
        wr(4'hF, 8'h03);
    endtask

    task automatic t_preamble();
        low_speed = 1'b1;
        wr(4'h0, 8'h87);
        @(negedge clk);
        check("R6 go ls", launch_go, 1);
        check("R6 pre masked ls", launch_preamble, 0);
        pulse_done();
        low_speed = 1'b0;
        wr(4'h0, 8'h87);
        @(negedge clk);
        check("R6 go fs", launch_go, 1);
        check("R6 pre fs", launch_preamble, 1);
        pulse_done();
        wr(4'hF, 8'h03);
    endtask

    task automatic t_sof();
        wr(4'h0, 8'h23);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R5 held for sof", launch_go, 0);
        end
        pulse_sof();
        @(negedge clk);
        check("R5 go after sof", launch_go, 1);
        pulse_done();
        low_speed = 1'b1;
        wr(4'h0, 8'h23);
        @(negedge clk);
        check("R5 sync ignored ls", launch_go, 1);
        pulse_done();
        low_speed = 1'b0;
        wr(4'hF, 8'h03);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        wr(4'h8, 8'h23);
        wr(4'h0, 8'h23);
        @(negedge clk);
        check("R7 both waiting", launch_go, 0);
        pulse_sof();
        @(negedge clk);
        check("R7 go", launch_go, 1);
        check("R7 A first", launch_bank, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 no go while busy", launch_go, 0);
            check("R8 busy", xfer_busy, 1);
        end
        pulse_done();
        rd(4'hF, d); check("R9 only A flag", d, 8'h01);
        rd(4'h8, d); check("R9 B still armed", d, 8'h23);
        rd(4'h0, d); check("R9 A disarmed", d, 8'h22);
        @(negedge clk);
        check("R7 B go after done", launch_go, 1);
        check("R7 B bank", launch_bank, 1);
        check("R7 B base", launch_base, 8'h80);
        pulse_done();
        rd(4'hF, d); check("R9 both flags", d, 8'h03);
        wr(4'hF, 8'h03);
        wr(4'h0, 8'h00);
        wr(4'h8, 8'h00);
    endtask

    task automatic t_stray_done();
        logic [7:0] d;
        wr(4'h0, 8'h02);
        pulse_done();
        rd(4'hF, d); check("R9 stray done no flag", d, 0);
        rd(4'h0, d); check("R9 stray done ctrl", d, 8'h02);
        check("R9 stray done irq", irq, 0);
    endtask

    task automatic t_rearm();
        logic [7:0] d;
        wr(4'h0, 8'h03);
        @(negedge clk);
        check("R11 first go", launch_go, 1);
        wr(4'h0, 8'h03);
        check("R11 no go on rearm", launch_go, 0);
        rd(4'h0, d); check("R11 arm reads 1", d, 8'h03);
        check("R11 still busy", xfer_busy, 1);
        pulse_done();
        rd(4'h0, d); check("R11 arm kept after done", d, 8'h03);
        rd(4'hF, d); check("R11 flag", d, 8'h01);
        @(negedge clk);
        check("R11 relaunch", launch_go, 1);
        pulse_done();
        rd(4'h0, d); check("R11 arm cleared second", d, 8'h02);
        wr(4'hF, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_enable_gate();
        t_out_launch();
        t_in_toggle();
        t_preamble();
        t_sof();
        t_priority();
        t_stray_done();
        t_rearm();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule